// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 15-bit virtual address into a 12-bit physical address. It walks a two-level page table that sits in a byte-wide physical memory made of 32-byte pages. Every table entry is one byte: a valid flag in bit 7 and a 7-bit frame number in bits 6:0. A base register holds the page number of the directory. Software loads it through its own write strobe.

A request is taken only while the walker is idle. The walker then reads a directory entry, a table entry and finally the data byte. It uses a one-byte read port with a request pulse and a response valid, and it keeps exactly one read in flight. The walk stops with a fault as soon as an entry at either level is invalid. Completion is a single-cycle done pulse. The pulse carries a fault flag, the physical address and the data byte.

Top module: `page_walk_unit`

## Requirements
- R1: After reset the walker is idle. busy_o, mem_req_o and done_o are all low until a request arrives.
- R2: The first read of a walk goes to byte address {base page, va[14:10]}.
- R3: When the directory entry has bit 7 clear, the walk ends with fault_o high after that single read.
- R4: When the directory entry is valid, the second read goes to {entry[6:0], va[9:5]}.
- R5: When the table entry has bit 7 clear, the walk ends with fault_o high after exactly two reads.
- R6: When both entries are valid, the third read goes to {table entry[6:0], va[4:0]}. done_o then reports that address on pa_o and the byte read there on data_o, with fault_o low.
- R7: done_o is high for exactly one cycle per walk. On a fault, pa_o and data_o read as zero during that cycle.
- R8: req_i has no effect while busy_o is high. No extra reads are issued and the walk in progress returns its own result.
- R9: A base load through base_we_i takes effect for the next accepted request. A load during a walk, or in the cycle a request is accepted, does not change that walk.
- R10: A new read is issued only after the previous read's mem_rvalid_i, and any read latency of one cycle or more is accepted.
- R11: With the base page set to 108, virtual address 0x611c goes through directory index 24 and table index 8. It resolves to physical address 0x6bc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_we_i | input | 1 | Load strobe for the directory base page |
| base_pfn_i | input | 7 | Directory base page number |
| req_i | input | 1 | Translation request |
| va_i | input | 15 | Virtual address of the request |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | One-cycle read request pulse |
| mem_addr_o | output | 12 | Read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Read data byte |
| done_o | output | 1 | Walk complete, one cycle |
| fault_o | output | 1 | Walk ended on an invalid entry |
| pa_o | output | 12 | Physical address, zero on fault |
| data_o | output | 8 | Data byte at pa_o, zero on fault |

## Verification
The bench builds the walker with its default sizes: 32-byte pages and 7-bit frame numbers. A 4096-byte memory model can therefore cover the entire physical space, the fixed 0x611c example included. A filled-in memory image places invalid entries at both levels within a few dozen pseudo-random addresses. Read latency changes from one walk to the next between one and four cycles. This exercises the wait states, a request held across a walk, and a base reload in the middle of a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_RD, ST_DIR_WT, ST_TBL_RD, ST_TBL_WT, ST_DAT_RD, ST_DAT_WT
  } walk_st_e;

  typedef enum logic [1:0] {SRC_DIR, SRC_TBL, SRC_DAT} addr_src_e;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int PFN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PFN_W-1:0] pfn_i,
  input  logic             snap_i,
  output logic [PFN_W-1:0] snap_o
);
  logic [PFN_W-1:0] base_q, snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      snap_q <= '0;
    end else begin
      if (we_i)   base_q <= pfn_i;
      // the walk sees the value held before this edge, never a same-cycle load
      if (snap_i) snap_q <= base_q;
    end
  end

  assign snap_o = snap_q;

  // R9
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(snap_q));
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int OFF_W = 5,
  parameter int PFN_W = 7,
  localparam int VA_W = 3 * OFF_W,
  localparam int PA_W = PFN_W + OFF_W
) (
  input  addr_src_e        src_i,
  input  logic [PFN_W-1:0] base_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [PFN_W-1:0] dir_pfn_i,
  input  logic [PFN_W-1:0] tbl_pfn_i,
  output logic [PA_W-1:0]  addr_o
);
  always_comb begin
    unique case (src_i)
      SRC_DIR: addr_o = {base_i, va_i[VA_W-1 -: OFF_W]};
      SRC_TBL: addr_o = {dir_pfn_i, va_i[2*OFF_W-1 -: OFF_W]};
      default: addr_o = {tbl_pfn_i, va_i[OFF_W-1:0]};
    endcase
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int PFN_W = 7,
  parameter int OFF_W = 5,
  localparam int ENT_W = PFN_W + 1,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             rvalid_i,
  input  logic [ENT_W-1:0] rdata_i,
  input  logic [PA_W-1:0]  addr_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             mem_req_o,
  output addr_src_e        src_o,
  output logic [PFN_W-1:0] dir_pfn_o,
  output logic [PFN_W-1:0] tbl_pfn_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [ENT_W-1:0] data_o
);
  walk_st_e state_q, state_d;
  logic ent_ok, in_ent_wt, fin_fault, fin_ok;
  logic done_q, fault_q;
  logic [PA_W-1:0]  pa_q;
  logic [ENT_W-1:0] data_q;
  logic [PFN_W-1:0] dir_pfn_q, tbl_pfn_q;

  assign ent_ok    = rdata_i[ENT_W-1];
  assign in_ent_wt = (state_q == ST_DIR_WT) || (state_q == ST_TBL_WT);
  assign fin_fault = in_ent_wt && rvalid_i && !ent_ok;
  assign fin_ok    = (state_q == ST_DAT_WT) && rvalid_i;
  assign accept_o  = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i) state_d = ST_DIR_RD;
      ST_DIR_RD: state_d = ST_DIR_WT;
      ST_DIR_WT: if (rvalid_i) state_d = ent_ok ? ST_TBL_RD : ST_IDLE;
      ST_TBL_RD: state_d = ST_TBL_WT;
      ST_TBL_WT: if (rvalid_i) state_d = ent_ok ? ST_DAT_RD : ST_IDLE;
      ST_DAT_RD: state_d = ST_DAT_WT;
      ST_DAT_WT: if (rvalid_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_TBL_RD, ST_TBL_WT: src_o = SRC_TBL;
      ST_DAT_RD, ST_DAT_WT: src_o = SRC_DAT;
      default:              src_o = SRC_DIR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      pa_q      <= '0;
      data_q    <= '0;
      dir_pfn_q <= '0;
      tbl_pfn_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_fault || fin_ok;
      fault_q <= fin_fault;
      pa_q    <= fin_ok ? addr_i : '0;
      data_q  <= fin_ok ? rdata_i : '0;
      if (state_q == ST_DIR_WT && rvalid_i) dir_pfn_q <= rdata_i[PFN_W-1:0];
      if (state_q == ST_TBL_WT && rvalid_i) tbl_pfn_q <= rdata_i[PFN_W-1:0];
    end
  end

  assign busy_o    = state_q != ST_IDLE;
  assign mem_req_o = (state_q == ST_DIR_RD) || (state_q == ST_TBL_RD) ||
                     (state_q == ST_DAT_RD);
  assign dir_pfn_o = dir_pfn_q;
  assign tbl_pfn_o = tbl_pfn_q;
  assign done_o    = done_q;
  assign fault_o   = fault_q;
  assign pa_o      = pa_q;
  assign data_o    = data_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (pa_o == '0 && data_o == '0));
  // R3
  dir_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIR_WT && rvalid_i && !ent_ok) |=> (done_o && fault_o && !busy_o));
endmodule

// File: rtl/page_walk_unit.sv
module page_walk_unit
  import ptw_pkg::*;
#(
  parameter int OFF_W = 5,
  parameter int PFN_W = 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   base_we_i,
  input  logic [PFN_W-1:0]       base_pfn_i,
  input  logic                   req_i,
  input  logic [3*OFF_W-1:0]     va_i,
  output logic                   busy_o,
  output logic                   mem_req_o,
  output logic [PFN_W+OFF_W-1:0] mem_addr_o,
  input  logic                   mem_rvalid_i,
  input  logic [PFN_W:0]         mem_rdata_i,
  output logic                   done_o,
  output logic                   fault_o,
  output logic [PFN_W+OFF_W-1:0] pa_o,
  output logic [PFN_W:0]         data_o
);
  localparam int VA_W = 3 * OFF_W;

  logic             accept;
  logic [VA_W-1:0]  va_q;
  logic [PFN_W-1:0] base_snap, dir_pfn, tbl_pfn;
  addr_src_e        src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     va_q <= '0;
    else if (accept) va_q <= va_i;
  end

  ptw_base_reg #(.PFN_W(PFN_W)) u_base (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (base_we_i),
    .pfn_i (base_pfn_i),
    .snap_i(accept),
    .snap_o(base_snap)
  );

  ptw_addr_gen #(.OFF_W(OFF_W), .PFN_W(PFN_W)) u_addr (
    .src_i    (src),
    .base_i   (base_snap),
    .va_i     (va_q),
    .dir_pfn_i(dir_pfn),
    .tbl_pfn_i(tbl_pfn),
    .addr_o   (mem_addr_o)
  );

  ptw_ctrl #(.PFN_W(PFN_W), .OFF_W(OFF_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .rvalid_i (mem_rvalid_i),
    .rdata_i  (mem_rdata_i),
    .addr_i   (mem_addr_o),
    .accept_o (accept),
    .busy_o   (busy_o),
    .mem_req_o(mem_req_o),
    .src_o    (src),
    .dir_pfn_o(dir_pfn),
    .tbl_pfn_o(tbl_pfn),
    .done_o   (done_o),
    .fault_o  (fault_o),
    .pa_o     (pa_o),
    .data_o   (data_o)
  );

  // checker state: reads per walk, outstanding read
  logic [1:0] rd_cnt_q;
  logic       outst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_q <= '0;
      outst_q  <= 1'b0;
    end else begin
      if (accept)         rd_cnt_q <= '0;
      else if (mem_req_o) rd_cnt_q <= rd_cnt_q + 2'd1;
      if (mem_req_o)         outst_q <= 1'b1;
      else if (mem_rvalid_i) outst_q <= 1'b0;
    end
  end

  // R6
  three_reads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> rd_cnt_q == 2'd3);
  // R5
  fault_reads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (rd_cnt_q == 2'd1 || rd_cnt_q == 2'd2));
  // R10
  one_outst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !outst_q);
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> $stable(va_q));
endmodule

// File: tb/page_walk_unit_tb_top.sv
module page_walk_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 12;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_ni = 1'b0;
  logic base_we_i = 1'b0;
  logic [6:0] base_pfn_i = '0;
  logic req_i = 1'b0;
  logic [14:0] va_i = '0;
  logic busy_o, mem_req_o, mem_rvalid_i, done_o, fault_o;
  logic [11:0] mem_addr_o, pa_o;
  logic [7:0] mem_rdata_i, data_o;

  page_walk_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .base_we_i(base_we_i), .base_pfn_i(base_pfn_i),
    .req_i(req_i), .va_i(va_i), .busy_o(busy_o), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .fault_o(fault_o), .pa_o(pa_o), .data_o(data_o)
  );

  typedef struct {
    bit          fault;
    logic [11:0] pa;
    logic [7:0]  data;
    int          nrd;
    string       tag;
  } res_t;

  int n_cmp = 0, n_bad = 0, cyc = 0, done_cnt = 0;
  bit finished = 1'b0;
  logic [7:0] mem [0:4095];
  int lat_cfg = 1, resp_cnt = 0, rd_seen = 0, model_base = 0;
  logic [PA_W-1:0] resp_addr = '0;
  logic [PA_W-1:0] exp_addr_q[$];
  string exp_tag_q[$];
  res_t exp_res_q[$];
  bit done_prev = 1'b0;
  logic [11:0] last_pa = '0;
  logic [7:0] last_data = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = '0;
    for (int a = 0; a < 4096; a++) mem[a] = 8'((a * 37 + (a >> 3) * 11 + 5) & 255);
    mem[108*32+24] = 8'ha1;
    mem[33*32+8]   = 8'hb5;
    mem[53*32+28]  = 8'h08;
    mem[108*32+3]  = 8'h21; // invalid directory entry
    mem[33*32+9]   = 8'h35; // invalid table entry
  end

  // memory model, reference model and per-cycle comparison
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      logic [11:0] a1, a2, a3;
      logic [7:0] pde, pte;
      res_t r;
      if (done_o && done_prev) chk(1'b0, "R7 done wider than one cycle", 1, 0);
      mem_rvalid_i = 1'b0;
      if (resp_cnt > 0) begin
        resp_cnt--;
        if (resp_cnt == 0) begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i  = mem[resp_addr];
        end
      end
      if (mem_req_o) begin
        rd_seen++;
        chk(resp_cnt == 0, "R10 read issued while one outstanding", resp_cnt, 0);
        if (exp_addr_q.size() == 0) chk(1'b0, "R8 unexpected read", int'(mem_addr_o), 0);
        else begin
          a1 = exp_addr_q.pop_front();
          chk(mem_addr_o == a1, exp_tag_q.pop_front(), int'(mem_addr_o), int'(a1));
        end
        resp_addr = mem_addr_o;
        resp_cnt  = lat_cfg;
      end
      if (done_o) begin
        done_cnt++;
        last_pa   = pa_o;
        last_data = data_o;
        if (exp_res_q.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
        else begin
          r = exp_res_q.pop_front();
          chk(fault_o == r.fault, {r.tag, " fault flag"}, int'(fault_o), int'(r.fault));
          chk(pa_o == r.pa, {r.tag, " pa"}, int'(pa_o), int'(r.pa));
          chk(data_o == r.data, {r.tag, " data"}, int'(data_o), int'(r.data));
          chk(rd_seen == r.nrd, {r.tag, " read count"}, rd_seen, r.nrd);
        end
      end
      if (req_i && !busy_o) begin
        rd_seen = 0;
        a1 = {7'(model_base), va_i[14:10]};
        exp_addr_q.push_back(a1); exp_tag_q.push_back("R2 directory address");
        pde = mem[a1];
        if (!pde[7]) r = '{1'b1, 12'h0, 8'h0, 1, "R3/R7 directory fault"};
        else begin
          a2 = {pde[6:0], va_i[9:5]};
          exp_addr_q.push_back(a2); exp_tag_q.push_back("R4 table address");
          pte = mem[a2];
          if (!pte[7]) r = '{1'b1, 12'h0, 8'h0, 2, "R5/R7 table fault"};
          else begin
            a3 = {pte[6:0], va_i[4:0]};
            exp_addr_q.push_back(a3); exp_tag_q.push_back("R6 data address");
            r = '{1'b0, a3, mem[a3], 3, "R6 success"};
          end
        end
        exp_res_q.push_back(r);
      end
      if (base_we_i) model_base = int'(base_pfn_i);
      done_prev = done_o;
    end
  end

  task automatic wait_done(input int n0);
    for (int i = 0; i < 500 && done_cnt == n0; i++) @(posedge clk);
    @(negedge clk);
    if (done_cnt == n0) chk(1'b0, "R10 walk never completed", 0, 1);
  endtask

  task automatic walk(input logic [14:0] va, input int lat);
    int n0;
    @(posedge clk); #1;
    n0 = done_cnt; lat_cfg = lat; req_i = 1'b1; va_i = va;
    @(posedge clk); #1;
    req_i = 1'b0;
    wait_done(n0);
  endtask

  task automatic load_base(input logic [6:0] p);
    @(posedge clk); #1;
    base_we_i = 1'b1; base_pfn_i = p;
    @(posedge clk); #1;
    base_we_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired R10 actual=%0d expected=%0d", cyc, 150000);
      report();
    end
  end

  initial begin
    logic [14:0] va;
    int n0;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy_o && !mem_req_o && !done_o, "R1 state in reset", {busy_o, mem_req_o, done_o}, 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !mem_req_o && !done_o, "R1 idle after reset", {busy_o, mem_req_o, done_o}, 0);

    load_base(7'd108); // R9
    walk(15'h611c, 1);
    chk(last_pa == 12'h6bc, "R11 physical address", int'(last_pa), 'h6bc);
    chk(last_data == 8'h08, "R11 data byte", int'(last_data), 8);
    walk(15'h611c, 4);
    walk({5'd3, 5'd7, 5'd2}, 2);   // R3 directory fault
    walk({5'd24, 5'd9, 5'd17}, 3); // R5 table fault

    // R8: request held high and changing while busy
    @(posedge clk); #1;
    n0 = done_cnt; lat_cfg = 3; req_i = 1'b1; va_i = 15'h611c;
    @(posedge clk); #1 va_i = 15'h0c41;
    repeat (3) @(posedge clk);
    #1 req_i = 1'b0;
    wait_done(n0);
    chk(last_pa == 12'h6bc, "R8 result of first request", int'(last_pa), 'h6bc);

    // R9: base reload in the middle of a walk
    @(posedge clk); #1;
    n0 = done_cnt; lat_cfg = 2; req_i = 1'b1; va_i = 15'h611c;
    @(posedge clk); #1 req_i = 1'b0;
    @(posedge clk); #1 base_we_i = 1'b1; base_pfn_i = 7'd50;
    @(posedge clk); #1 base_we_i = 1'b0;
    wait_done(n0);
    chk(last_pa == 12'h6bc, "R9 walk kept old base", int'(last_pa), 'h6bc);
    walk(15'h611c, 1);
    load_base(7'd108);

    // mixed addresses and latencies
    va = 15'h1234;
    for (int i = 0; i < 60; i++) begin
      va = 15'(va * 13 + 15'h2a7 + i);
      walk(va, 1 + (i % 4));
      if (i == 30) load_base(7'd77);
    end

    repeat (5) @(negedge clk);
    chk(exp_res_q.size() == 0 && exp_addr_q.size() == 0, "R8 leftover expectations",
        exp_res_q.size() + exp_addr_q.size(), 0);
    chk(!busy_o, "R1 idle at end", int'(busy_o), 0);
    finished = 1'b1;
    report();
  end
endmodule